// File: doc/BRIEF.md
# Interrupt presentation priority controller

This unit sits in front of one processor. It holds at most one pending interrupt and drives a single interrupt line toward the core. Source controllers offer interrupts as a (source number, priority) pair. The unit answers each offer in the same cycle: the offer is either taken or refused. When a better offer displaces an interrupt that a source owns, the unit sends that displaced source number back to its source as a reject on a separate pulse output.

The processor controls the unit with five register-style commands: write the current processor priority, write the inter-processor-interrupt (IPI) request priority, accept, poll, and end-of-interrupt. Accept reads and acknowledges the pending interrupt. Poll reads without side effects. A command that leaves nothing pending asks the sources to resend. The presentation word is 32 bits wide. Bits 31:24 hold the current processor priority and bits 23:0 hold the pending source number. A source number of zero means nothing is pending. A lower number is a more favoured priority, and 0xFF is the fully masked level.

The offer port is a valid/ready stream. `offer_ready` is low in any cycle in which `cmd_valid` is high. In that case the source must hold its offer, and commands always win. When `offer_valid` and `offer_ready` are both high, the offer is consumed in that cycle. `offer_ok` high means taken. `offer_ok` low means refused, and the source keeps the interrupt itself. Command results, rejects, EOI forwards and resend requests appear as one-cycle pulses in the cycle after the command or offer.

Top module: `ipc_presenter`

## Requirements
- R1: After reset the presentation word is 0, the pending priority and the IPI priority are 0xFF, and `irq_out` is low.
- R2: An offer is refused when its priority is greater than or equal to the current processor priority.
- R3: An offer is refused when an interrupt is already pending at a priority less than or equal to the offered one. An offer with source number 0 is never taken.
- R4: A taken offer becomes the pending source and priority and raises `irq_out`. A displaced pending interrupt that a source owns is reported on `rej_valid`/`rej_src` one cycle later.
- R5: Accept (`cmd_op`=2) returns the old presentation word on `rd_word` one cycle later. It lowers `irq_out`, sets the current priority to the old pending priority, clears the source field, and sets the pending priority to 0xFF.
- R6: Writing the current priority (`cmd_op`=0, value in `cmd_data[7:0]`) lower than before, while an interrupt is pending at a priority the new value does not beat, clears the pending interrupt, lowers `irq_out`, and rejects a source-owned one.
- R7: Writing an equal or higher current priority while nothing is pending pulses `resend_req`. Before that, it loads the IPI if the IPI priority is below the new current priority.
- R8: Writing the IPI priority (`cmd_op`=1, value in `cmd_data[7:0]`) below the current priority loads source number 2 at that priority and raises `irq_out`. The exception is when something is already pending at a priority less than or equal to it.
- R9: An IPI-sourced pending interrupt has no owning source, so displacing it produces no reject pulse.
- R10: End-of-interrupt (`cmd_op`=4) sets the current priority from `cmd_data[31:24]` and forwards `cmd_data[23:0]` on `eoi_src`. If nothing is pending, it also performs the resend of R7.
- R11: Poll (`cmd_op`=3) returns the presentation word on `rd_word` and the IPI priority on `rd_ipi`, and changes no state.
- R12: `offer_ready` is low whenever `cmd_valid` is high, and no offer is taken in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | A source offers an interrupt |
| offer_ready | output | 1 | Offer can be consumed this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_ok | output | 1 | Consumed offer is taken (low = refused) |
| rej_valid | output | 1 | Displaced interrupt returned to its source |
| rej_src | output | 24 | Source number being returned |
| resend_req | output | 1 | Sources are asked to resend |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | 0 prio write, 1 IPI write, 2 accept, 3 poll, 4 EOI |
| cmd_data | input | 32 | Command operand |
| rd_valid | output | 1 | Read result valid |
| rd_word | output | 32 | Presentation word read |
| rd_ipi | output | 8 | IPI priority read |
| eoi_valid | output | 1 | EOI forwarded to sources |
| eoi_src | output | 24 | Source number of the EOI |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The bench goes after offers whose priority ties the current or the pending priority. A design that used strict comparisons there would take equal-priority offers and bounce interrupts back and forth. It also checks that displacing an IPI produces no reject, because a design that tracked no owner would send source 2 back to a source that never offered it. It checks that lowering the current priority sheds the pending interrupt and that an EOI with nothing pending re-arms the IPI before asking for resends. A design that got these wrong would either leave the line up for an interrupt the core has masked or lose a software interrupt. A long random command and offer mix, including offers that collide with commands, compares every output on every cycle against a behavioural model.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_SET_CPPR = 3'd0,
    OP_SET_IPI  = 3'd1,
    OP_ACCEPT   = 3'd2,
    OP_POLL     = 3'd3,
    OP_EOI      = 3'd4
  } ipc_op_e;
endpackage

// File: rtl/ipc_offer_judge.sv
// Decides whether an offer that is consumed this cycle is taken.
module ipc_offer_judge #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic              offer_valid,
  input  logic              offer_ready,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              pend_nz,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              take
);
  logic beats_cpu;
  logic beats_pending;

  assign beats_cpu     = offer_prio < cur_prio;
  assign beats_pending = !pend_nz || (offer_prio < pend_prio);
  assign take = offer_valid && offer_ready && (offer_src != '0) &&
                beats_cpu && beats_pending;
endmodule

// File: rtl/ipc_ipi_eval.sv
// Says whether the software interrupt should be loaded as pending.
module ipc_ipi_eval #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              pend_nz,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              fire
);
  logic held_by_better;

  assign held_by_better = pend_nz && (pend_prio <= ipi_prio);
  assign fire = (ipi_prio < cur_prio) && !held_by_better;
endmodule

// File: rtl/ipc_evt_reg.sv
// One-cycle event pulse with a captured payload.
module ipc_evt_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [W-1:0] din,
  output logic         vld,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      dout <= '0;
    end else begin
      vld <= set;
      if (set) dout <= din;
    end
  end
endmodule

// File: rtl/ipc_presenter.sv
module ipc_presenter #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    offer_valid,
  output logic                    offer_ready,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic [PRIO_W-1:0]       offer_prio,
  output logic                    offer_ok,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    resend_req,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd_op,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data,
  output logic                    rd_valid,
  output logic [PRIO_W+SRC_W-1:0] rd_word,
  output logic [PRIO_W-1:0]       rd_ipi,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    irq_out
);
  import ipc_pkg::*;

  localparam int REG_W = PRIO_W + SRC_W;
  localparam int RD_W  = REG_W + PRIO_W;
  localparam logic [PRIO_W-1:0] MASKED  = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [SRC_W-1:0]  xisr_q, xisr_d;
  logic [PRIO_W-1:0] pp_q, pp_d;
  logic [PRIO_W-1:0] mfrr_q, mfrr_d;
  logic              irq_q, irq_d;
  logic              own_q, own_d;
  logic              resend_q, resend_d;

  logic              pend_nz;
  logic [PRIO_W-1:0] wr_prio;
  ipc_op_e           op;

  logic [PRIO_W-1:0] ipi_m, ipi_c;
  logic              ipi_nz;
  logic              ipi_fire;

  logic              rej_set, eoi_set, rd_set;
  logic [RD_W-1:0]   rd_bus;

  assign pend_nz     = xisr_q != '0;
  assign wr_prio     = cmd_data[PRIO_W-1:0];
  assign op          = ipc_op_e'(cmd_op);
  assign offer_ready = !cmd_valid;

  ipc_offer_judge #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_judge (
    .offer_valid (offer_valid),
    .offer_ready (offer_ready),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .cur_prio    (cppr_q),
    .pend_nz     (pend_nz),
    .pend_prio   (pp_q),
    .take        (offer_ok)
  );

  // Operands for the IPI check depend on which command requests it.
  always_comb begin
    ipi_m  = mfrr_q;
    ipi_c  = cppr_q;
    ipi_nz = pend_nz;
    case (op)
      OP_SET_IPI: begin
        ipi_m  = wr_prio;
        ipi_c  = cppr_q;
        ipi_nz = pend_nz;
      end
      OP_SET_CPPR: begin
        ipi_c  = wr_prio;
        ipi_nz = 1'b0;
      end
      OP_EOI: begin
        ipi_c  = cmd_data[REG_W-1:SRC_W];
        ipi_nz = 1'b0;
      end
      default: ;
    endcase
  end

  ipc_ipi_eval #(.PRIO_W(PRIO_W)) u_ipi (
    .ipi_prio  (ipi_m),
    .cur_prio  (ipi_c),
    .pend_nz   (ipi_nz),
    .pend_prio (pp_q),
    .fire      (ipi_fire)
  );

  // Next-state logic: commands take precedence over offers.
  always_comb begin
    cppr_d   = cppr_q;
    xisr_d   = xisr_q;
    pp_d     = pp_q;
    mfrr_d   = mfrr_q;
    irq_d    = irq_q;
    own_d    = own_q;
    resend_d = 1'b0;
    rej_set  = 1'b0;
    eoi_set  = 1'b0;
    rd_set   = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_SET_CPPR: begin
          cppr_d = wr_prio;
          if (wr_prio < cppr_q) begin
            if (pend_nz && (wr_prio <= pp_q)) begin
              rej_set = own_q;
              xisr_d  = '0;
              pp_d    = MASKED;
              irq_d   = 1'b0;
              own_d   = 1'b0;
            end
          end else if (!pend_nz) begin
            resend_d = 1'b1;
            if (ipi_fire) begin
              xisr_d = IPI_NUM;
              pp_d   = ipi_m;
              irq_d  = 1'b1;
              own_d  = 1'b0;
            end
          end
        end
        OP_SET_IPI: begin
          mfrr_d = wr_prio;
          if (ipi_fire) begin
            rej_set = pend_nz && own_q;
            xisr_d  = IPI_NUM;
            pp_d    = ipi_m;
            irq_d   = 1'b1;
            own_d   = 1'b0;
          end
        end
        OP_ACCEPT: begin
          rd_set = 1'b1;
          cppr_d = pp_q;
          xisr_d = '0;
          pp_d   = MASKED;
          irq_d  = 1'b0;
          own_d  = 1'b0;
        end
        OP_POLL: begin
          rd_set = 1'b1;
        end
        OP_EOI: begin
          eoi_set = 1'b1;
          cppr_d  = cmd_data[REG_W-1:SRC_W];
          if (!pend_nz) begin
            resend_d = 1'b1;
            if (ipi_fire) begin
              xisr_d = IPI_NUM;
              pp_d   = ipi_m;
              irq_d  = 1'b1;
              own_d  = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end else if (offer_ok) begin
      rej_set = pend_nz && own_q;
      xisr_d  = offer_src;
      pp_d    = offer_prio;
      irq_d   = 1'b1;
      own_d   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q   <= '0;
      xisr_q   <= '0;
      pp_q     <= MASKED;
      mfrr_q   <= MASKED;
      irq_q    <= 1'b0;
      own_q    <= 1'b0;
      resend_q <= 1'b0;
    end else begin
      cppr_q   <= cppr_d;
      xisr_q   <= xisr_d;
      pp_q     <= pp_d;
      mfrr_q   <= mfrr_d;
      irq_q    <= irq_d;
      own_q    <= own_d;
      resend_q <= resend_d;
    end
  end

  assign rd_bus = {cppr_q, xisr_q, mfrr_q};

  ipc_evt_reg #(.W(SRC_W)) u_rej (
    .clk (clk), .rst_n (rst_n), .set (rej_set), .din (xisr_q),
    .vld (rej_valid), .dout (rej_src)
  );

  ipc_evt_reg #(.W(SRC_W)) u_eoi (
    .clk (clk), .rst_n (rst_n), .set (eoi_set), .din (cmd_data[SRC_W-1:0]),
    .vld (eoi_valid), .dout (eoi_src)
  );

  logic [RD_W-1:0] rd_q;
  ipc_evt_reg #(.W(RD_W)) u_rd (
    .clk (clk), .rst_n (rst_n), .set (rd_set), .din (rd_bus),
    .vld (rd_valid), .dout (rd_q)
  );

  assign rd_word    = rd_q[RD_W-1:PRIO_W];
  assign rd_ipi     = rd_q[PRIO_W-1:0];
  assign resend_req = resend_q;
  assign irq_out    = irq_q;
endmodule

// File: rtl/ipc_presenter_chk.sv
module ipc_presenter_chk #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    offer_valid,
  input logic                    offer_ready,
  input logic                    offer_ok,
  input logic [PRIO_W-1:0]       offer_prio,
  input logic                    cmd_valid,
  input logic [2:0]              cmd_op,
  input logic [PRIO_W+SRC_W-1:0] cmd_data,
  input logic                    rd_valid,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic                    irq_out,
  input logic [PRIO_W-1:0]       cppr_q,
  input logic [SRC_W-1:0]        xisr_q,
  input logic [PRIO_W-1:0]       pp_q,
  input logic [PRIO_W-1:0]       mfrr_q
);
  // R4
  irq_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr_q != '0));

  // R2
  take_beats_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_ok |-> (offer_prio < cppr_q));

  // R12
  take_needs_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_ok |-> (offer_valid && offer_ready && !cmd_valid));

  // R5
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> (!irq_out && rd_valid && xisr_q == '0 && pp_q == '1));

  // R11
  poll_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3) |=> (rd_valid && xisr_q == $past(xisr_q) &&
      cppr_q == $past(cppr_q) && pp_q == $past(pp_q) && mfrr_q == $past(mfrr_q)));

  // R10
  eoi_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0])));

  // R4
  reject_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0));
endmodule

bind ipc_presenter ipc_presenter_chk #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .offer_valid (offer_valid), .offer_ready (offer_ready),
  .offer_ok (offer_ok), .offer_prio (offer_prio), .cmd_valid (cmd_valid),
  .cmd_op (cmd_op), .cmd_data (cmd_data), .rd_valid (rd_valid),
  .rej_valid (rej_valid), .rej_src (rej_src), .eoi_valid (eoi_valid),
  .eoi_src (eoi_src), .irq_out (irq_out), .cppr_q (cppr_q), .xisr_q (xisr_q),
  .pp_q (pp_q), .mfrr_q (mfrr_q)
);

// File: tb/ipc_presenter_tb.sv
`timescale 1ns/1ps
module ipc_presenter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic        offer_ready;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        offer_ok;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic        resend_req;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        rd_valid;
  logic [31:0] rd_word;
  logic [7:0]  rd_ipi;
  logic        eoi_valid;
  logic [23:0] eoi_src;
  logic        irq_out;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ipc_presenter u_dut (
    .clk (clk), .rst_n (rst_n), .offer_valid (offer_valid), .offer_ready (offer_ready),
    .offer_src (offer_src), .offer_prio (offer_prio), .offer_ok (offer_ok),
    .rej_valid (rej_valid), .rej_src (rej_src), .resend_req (resend_req),
    .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_data (cmd_data),
    .rd_valid (rd_valid), .rd_word (rd_word), .rd_ipi (rd_ipi),
    .eoi_valid (eoi_valid), .eoi_src (eoi_src), .irq_out (irq_out)
  );

  // Behavioural model state
  bit [7:0]  m_cppr, m_pp, m_mfrr;
  bit [23:0] m_src;
  bit        m_owned, m_irq;
  bit        m_rej_v, m_resend, m_eoi_v, m_rd_v;
  bit [23:0] m_rej_src, m_eoi_src;
  bit [31:0] m_rd_word;
  bit [7:0]  m_rd_ipi;

  task automatic chk(string req, string what, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cppr = 8'h00; m_src = '0; m_pp = 8'hFF; m_mfrr = 8'hFF;
    m_owned = 0; m_irq = 0;
    m_rej_v = 0; m_resend = 0; m_eoi_v = 0; m_rd_v = 0;
  endtask

  function automatic bit model_takes();
    if (!offer_valid || cmd_valid || offer_src == 0) return 0;
    if (offer_prio >= m_cppr) return 0;
    if (m_src != 0 && m_pp <= offer_prio) return 0;
    return 1;
  endfunction

  task automatic give_back(bit [23:0] s);
    m_rej_v = 1; m_rej_src = s;
  endtask

  task automatic try_ipi(bit [7:0] lvl);
    if (m_src != 0 && m_pp <= lvl) return;
    if (m_src != 0 && m_owned) give_back(m_src);
    m_src = 24'd2; m_pp = lvl; m_irq = 1; m_owned = 0;
  endtask

  task automatic do_resend();
    if (m_mfrr < m_cppr) try_ipi(m_mfrr);
    m_resend = 1;
  endtask

  task automatic model_clock();
    bit take;
    bit [7:0] prev;
    take = model_takes();
    m_rej_v = 0; m_resend = 0; m_eoi_v = 0; m_rd_v = 0;
    if (cmd_valid) begin
      case (cmd_op)
        3'd0: begin
          prev = m_cppr;
          m_cppr = cmd_data[7:0];
          if (m_cppr < prev) begin
            if (m_src != 0 && m_cppr <= m_pp) begin
              if (m_owned) give_back(m_src);
              m_src = 0; m_pp = 8'hFF; m_irq = 0; m_owned = 0;
            end
          end else if (m_src == 0) do_resend();
        end
        3'd1: begin
          m_mfrr = cmd_data[7:0];
          if (m_mfrr < m_cppr) try_ipi(m_mfrr);
        end
        3'd2: begin
          m_rd_v = 1; m_rd_word = {m_cppr, m_src}; m_rd_ipi = m_mfrr;
          m_cppr = m_pp; m_src = 0; m_pp = 8'hFF; m_irq = 0; m_owned = 0;
        end
        3'd3: begin
          m_rd_v = 1; m_rd_word = {m_cppr, m_src}; m_rd_ipi = m_mfrr;
        end
        3'd4: begin
          m_cppr = cmd_data[31:24];
          m_eoi_v = 1; m_eoi_src = cmd_data[23:0];
          if (m_src == 0) do_resend();
        end
        default: ;
      endcase
    end else if (take) begin
      if (m_src != 0 && m_owned) give_back(m_src);
      m_src = offer_src; m_pp = offer_prio; m_irq = 1; m_owned = 1;
    end
  endtask

  task automatic check_regs();
    chk("R4", "irq_out", irq_out, m_irq);
    chk("R5", "rd_valid", rd_valid, m_rd_v);
    if (m_rd_v) begin
      chk("R11", "rd_word", rd_word, m_rd_word);
      chk("R11", "rd_ipi", rd_ipi, m_rd_ipi);
    end
    chk("R9", "rej_valid", rej_valid, m_rej_v);
    if (m_rej_v) chk("R4", "rej_src", rej_src, m_rej_src);
    chk("R7", "resend_req", resend_req, m_resend);
    chk("R10", "eoi_valid", eoi_valid, m_eoi_v);
    if (m_eoi_v) chk("R10", "eoi_src", eoi_src, m_eoi_src);
  endtask

  task automatic step(bit ov, bit [23:0] os, bit [7:0] opr, bit cv, bit [2:0] op, bit [31:0] d);
    @(negedge clk);
    check_regs();
    offer_valid = ov; offer_src = os; offer_prio = opr;
    cmd_valid = cv; cmd_op = op; cmd_data = d;
    #1;
    chk("R12", "offer_ready", offer_ready, !cv);
    chk("R3", "offer_ok", offer_ok, model_takes());
    @(posedge clk);
    model_clock();
  endtask

  task automatic offer(bit [23:0] s, bit [7:0] p); step(1, s, p, 0, 0, 0); endtask
  task automatic cmd(bit [2:0] op, bit [31:0] d); step(0, 0, 0, 1, op, d); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen through poll
    cmd(3'd3, 0);
    @(negedge clk);
    chk("R1", "reset word", rd_word, 32'h0);
    chk("R1", "reset ipi", rd_ipi, 8'hFF);
    chk("R1", "reset irq", irq_out, 1'b0);
    // R2: current priority 0 refuses everything
    offer(24'd5, 8'd3);
    // R7: raise current priority while empty -> resend, no IPI
    cmd(3'd0, 32'hFF);
    idle();
    chk("R7", "resend after raise", resend_req, 1'b1);
    // R4: first offer taken
    offer(24'd5, 8'd8);
    // R3: equal and worse offers refused
    offer(24'd6, 8'd8);
    offer(24'd7, 8'd9);
    // R4: better offer displaces source 5
    offer(24'd9, 8'd4);
    idle();
    chk("R4", "displaced source", rej_src, 24'd5);
    // R11: poll
    cmd(3'd3, 0);
    // R5: accept returns FF000009 and lowers line
    cmd(3'd2, 0);
    idle();
    chk("R5", "accept word", rd_word, 32'hFF000009);
    chk("R5", "irq after accept", irq_out, 1'b0);
    // R6: pending at 2, write priority 2 sheds it
    offer(24'd11, 8'd2);
    cmd(3'd0, 32'h2);
    idle();
    chk("R6", "shed reject", rej_src, 24'd11);
    // R8: IPI below priority loads source 2
    cmd(3'd1, 32'h1);
    cmd(3'd3, 0);
    idle();
    chk("R8", "ipi pending word", rd_word, 32'h02000002);
    // R9: offer at 0 displaces IPI without a reject
    offer(24'd12, 8'd0);
    cmd(3'd2, 0);
    idle();
    chk("R9", "accept after ipi displace", rd_word, 32'h0200000C);
    // R10: EOI with nothing pending re-arms IPI and resends
    cmd(3'd4, 32'hFF00000C);
    idle();
    chk("R10", "irq after eoi", irq_out, 1'b1);
    cmd(3'd1, 32'hFF);
    cmd(3'd2, 0);
    cmd(3'd4, 32'hFF000002);
    // R3: zero source never taken; R12: offer during command held off
    offer(24'd0, 8'd5);
    step(1, 24'd4, 8'd5, 1, 3'd3, 0);
    offer(24'd4, 8'd5);
    idle();
    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] pr;
      bit [7:0] v;
      pr = ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 7));
      v  = ($urandom_range(0, 4) == 0) ? 8'hFF : 8'($urandom_range(0, 8));
      step($urandom_range(0, 9) < 6, 24'($urandom_range(0, 15)), pr,
           $urandom_range(0, 1) == 1, 3'($urandom_range(0, 5)),
           {v, 16'h0, 8'($urandom_range(0, 15))});
    end
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule